// File: doc/BRIEF.md
# Pipelined Control Decode and Stage Propagation

This block turns the 6-bit major opcode of a small load/store instruction subset into the control bits a five-stage datapath needs. It supports register-register arithmetic, word load, word store and branch-on-equal. The controls are decoded once, in the decode stage. They are split into three bundles by the stage that consumes them: execute, memory access and write-back. Each bundle then travels down the pipeline in the stage registers. Every downstream stage reads its controls from its own register, and no central sequencer is involved.

The decode-to-execute register holds all three bundles. The execute-to-memory register keeps the memory and write-back bundles. The memory-to-write-back register keeps only the write-back bundle. A stall request or a flush request forces an all-zero bubble into the decode-to-execute register in place of the decoded controls, so the instruction that moves forward can write neither memory nor the register file. Instructions already further down keep advancing. A synchronous reset clears every stage register.

The decoder names five instruction classes: `CLS_ALU`, `CLS_LOAD`, `CLS_STORE`, `CLS_BRANCH` and `CLS_NONE`. The class is selected combinationally from the opcode each cycle, with no state held between cycles. The only sequential behaviour is the fixed three-step march of the bundles through the stage registers. That march has two transitions: advance, or replace the decode-stage entry with a bubble.

Top module: `stage_ctl_pipe`

## Requirements
- R1: Opcode 0x00 (register-register class) decodes to dst_sel=1, alu_op=2'b10, imm_sel=0, branch=0, mem_rd=0, mem_wr=0, reg_wr=1, mem_to_reg=0.
- R2: Opcode 0x23 (word load) decodes to dst_sel=0, alu_op=2'b00, imm_sel=1, branch=0, mem_rd=1, mem_wr=0, reg_wr=1, mem_to_reg=1.
- R3: Opcode 0x2B (word store) decodes to alu_op=2'b00, imm_sel=1, mem_wr=1, and all other bits 0, with dst_sel and mem_to_reg driven to 0.
- R4: Opcode 0x04 (branch-on-equal) decodes to alu_op=2'b01, branch=1, and all other bits 0.
- R5: Any other opcode decodes to all-zero controls.
- R6: Port encodings are ex_ctl = {dst_sel, alu_op[1:0], imm_sel}, mem_ctl = {branch, mem_rd, mem_wr} and wb_ctl = {reg_wr, mem_to_reg}. An opcode sampled at clock edge k appears on ex_ctl after edge k, on mem_ctl after edge k+1 and on wb_ctl after edge k+2.
- R7: When stall is high at an edge, the decode-to-execute register loads all zeros, and the bundles already in the later stages still advance that edge.
- R8: When flush is high at an edge, the decode-to-execute register loads all zeros in the same way as for a stall, and having both requests high at once gives the same result.
- R9: When rst is high at an edge, all three stage registers become zero, whatever the opcode, stall and flush inputs are.
- R10: At most one of branch, mem_rd and mem_wr is ever 1 on mem_ctl, and mem_to_reg=1 on wb_ctl only occurs together with reg_wr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Major opcode of the instruction in decode |
| stall | input | 1 | Insert a bubble into the execute stage |
| flush | input | 1 | Discard the decode-stage instruction as a bubble |
| ex_ctl | output | 4 | Execute-stage bundle {dst_sel, alu_op, imm_sel} |
| mem_ctl | output | 3 | Memory-stage bundle {branch, mem_rd, mem_wr} |
| wb_ctl | output | 2 | Write-back bundle {reg_wr, mem_to_reg} |

## Verification
Two functions can fall in the same cycle: bubble insertion at the decode-to-execute register, and the ordinary advance of older instructions through the memory and write-back stages. The bench provokes this by raising stall or flush, or both, while a load or a register-register instruction is still one or two stages downstream. It then judges each stage separately against a behavioural three-entry model. The model expects zeros only in the execute bundle and unchanged forward movement elsewhere. Reset arriving in the middle of such a stream, and a pseudo-random mix of opcodes and requests, are compared on every clock in the same way.

// File: rtl/stage_ctl_pkg.sv
package stage_ctl_pkg;

    typedef struct packed {
        logic       dst_sel;
        logic [1:0] alu_op;
        logic       imm_sel;
    } ex_bundle_t;

    typedef struct packed {
        logic branch;
        logic mem_rd;
        logic mem_wr;
    } m_bundle_t;

    typedef struct packed {
        logic reg_wr;
        logic mem_to_reg;
    } wb_bundle_t;

    typedef struct packed {
        ex_bundle_t ex;
        m_bundle_t  m;
        wb_bundle_t wb;
    } idex_ctl_t;

    typedef struct packed {
        m_bundle_t  m;
        wb_bundle_t wb;
    } exmem_ctl_t;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } instr_class_t;

    localparam int EX_W    = $bits(ex_bundle_t);
    localparam int M_W     = $bits(m_bundle_t);
    localparam int WB_W    = $bits(wb_bundle_t);
    localparam int IDEX_W  = $bits(idex_ctl_t);
    localparam int EXMEM_W = $bits(exmem_ctl_t);

endpackage

// File: rtl/stage_ctl_decode.sv
module stage_ctl_decode
    import stage_ctl_pkg::*;
#(
    parameter int             OPW       = 6,
    parameter logic [OPW-1:0] OP_ALU    = 'h00,
    parameter logic [OPW-1:0] OP_LOAD   = 'h23,
    parameter logic [OPW-1:0] OP_STORE  = 'h2B,
    parameter logic [OPW-1:0] OP_BRANCH = 'h04
) (
    input  logic [OPW-1:0] opcode,
    output instr_class_t   cls,
    output idex_ctl_t      ctl
);

    always_comb begin
        if (opcode == OP_ALU)         cls = CLS_ALU;
        else if (opcode == OP_LOAD)   cls = CLS_LOAD;
        else if (opcode == OP_STORE)  cls = CLS_STORE;
        else if (opcode == OP_BRANCH) cls = CLS_BRANCH;
        else                          cls = CLS_NONE;
    end

    always_comb begin
        ctl = '0;
        unique case (cls)
            CLS_ALU: begin
                ctl.ex.dst_sel   = 1'b1;
                ctl.ex.alu_op    = 2'b10;
                ctl.wb.reg_wr    = 1'b1;
            end
            CLS_LOAD: begin
                ctl.ex.imm_sel   = 1'b1;
                ctl.m.mem_rd     = 1'b1;
                ctl.wb.reg_wr    = 1'b1;
                ctl.wb.mem_to_reg = 1'b1;
            end
            CLS_STORE: begin
                ctl.ex.imm_sel   = 1'b1;
                ctl.m.mem_wr     = 1'b1;
            end
            CLS_BRANCH: begin
                ctl.ex.alu_op    = 2'b01;
                ctl.m.branch     = 1'b1;
            end
            CLS_NONE: begin
                ctl = '0;
            end
            default: begin
                ctl = '0;
            end
        endcase
    end

    // R3: a memory write must never also write the register file
    always_comb begin
        if (ctl.m.mem_wr)
            p_store_no_regwr_r3: assert (!ctl.wb.reg_wr);
    end

endmodule

// File: rtl/stage_ctl_reg.sv
module stage_ctl_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else            q <= d;
    end

endmodule

// File: rtl/stage_ctl_pipe.sv
module stage_ctl_pipe
    import stage_ctl_pkg::*;
#(
    parameter int OPW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    input  logic           stall,
    input  logic           flush,
    output logic [EX_W-1:0] ex_ctl,
    output logic [M_W-1:0]  mem_ctl,
    output logic [WB_W-1:0] wb_ctl
);

    instr_class_t dec_cls;
    idex_ctl_t    dec_ctl;
    idex_ctl_t    idex_q;
    exmem_ctl_t   exmem_d;
    exmem_ctl_t   exmem_q;
    wb_bundle_t   memwb_q;
    logic         bubble;

    assign bubble = stall | flush;

    stage_ctl_decode #(.OPW(OPW)) u_decode (
        .opcode (opcode),
        .cls    (dec_cls),
        .ctl    (dec_ctl)
    );

    stage_ctl_reg #(.W(IDEX_W)) u_idex (
        .clk (clk),
        .rst (rst),
        .clr (bubble),
        .d   (dec_ctl),
        .q   (idex_q)
    );

    assign exmem_d.m  = idex_q.m;
    assign exmem_d.wb = idex_q.wb;

    stage_ctl_reg #(.W(EXMEM_W)) u_exmem (
        .clk (clk),
        .rst (rst),
        .clr (1'b0),
        .d   (exmem_d),
        .q   (exmem_q)
    );

    stage_ctl_reg #(.W(WB_W)) u_memwb (
        .clk (clk),
        .rst (rst),
        .clr (1'b0),
        .d   (exmem_q.wb),
        .q   (memwb_q)
    );

    assign ex_ctl  = idex_q.ex;
    assign mem_ctl = exmem_q.m;
    assign wb_ctl  = memwb_q;

    // R7: a stall leaves a full bubble in the execute stage
    p_stall_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> (idex_q == '0));

    // R8: a flush leaves a full bubble in the execute stage
    p_flush_bubble_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (idex_q == '0 && ex_ctl == '0));

    // R6: memory bundle is the one the execute stage held a cycle earlier
    p_mem_follows_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mem_ctl == $past(idex_q.m)));

    // R6: write-back bundle is the one the memory stage held a cycle earlier
    p_wb_follows_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wb_ctl == $past(exmem_q.wb)));

    // R10: memory-stage actions are mutually exclusive
    p_mem_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_ctl));

    // R10: selecting memory data for write-back implies a register write
    p_wb_consistent_r10: assert property (@(posedge clk) disable iff (rst)
        wb_ctl[0] |-> wb_ctl[1]);

endmodule

// File: tb/stage_ctl_pipe_test.sv
`timescale 1ns/1ps
module stage_ctl_pipe_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic       stall;
    logic       flush;
    logic [3:0] ex_ctl;
    logic [2:0] mem_ctl;
    logic [1:0] wb_ctl;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R9";

    // behavioural model: three stage slots
    logic [8:0] m_idex  = '0;
    logic [4:0] m_exmem = '0;
    logic [1:0] m_memwb = '0;

    always #2 clk = ~clk;

    stage_ctl_pipe uut (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .stall   (stall),
        .flush   (flush),
        .ex_ctl  (ex_ctl),
        .mem_ctl (mem_ctl),
        .wb_ctl  (wb_ctl)
    );

    // {ex[3:0], m[2:0], wb[1:0]} straight from the requirement tables
    function automatic logic [8:0] expect_dec(input logic [5:0] op);
        case (op)
            6'h00:   return {4'b1100, 3'b000, 2'b10};
            6'h23:   return {4'b0001, 3'b010, 2'b11};
            6'h2B:   return {4'b0001, 3'b001, 2'b00};
            6'h04:   return {4'b0010, 3'b100, 2'b00};
            default: return 9'd0;
        endcase
    endfunction

    task automatic compare();
        checks++;
        if (ex_ctl !== m_idex[8:5]) begin
            fails++;
            $display("FAIL %s ex_ctl actual=%b expected=%b", tag, ex_ctl, m_idex[8:5]);
        end
        checks++;
        if (mem_ctl !== m_exmem[4:2]) begin
            fails++;
            $display("FAIL %s mem_ctl actual=%b expected=%b", tag, mem_ctl, m_exmem[4:2]);
        end
        checks++;
        if (wb_ctl !== m_memwb) begin
            fails++;
            $display("FAIL %s wb_ctl actual=%b expected=%b", tag, wb_ctl, m_memwb);
        end
    endtask

    task automatic step(input logic [5:0] op, input logic st, input logic fl,
                        input logic rs);
        opcode = op;
        stall  = st;
        flush  = fl;
        rst    = rs;
        @(posedge clk);
        if (rs) begin
            m_memwb = '0;
            m_exmem = '0;
            m_idex  = '0;
        end else begin
            m_memwb = m_exmem[1:0];
            m_exmem = m_idex[4:0];
            m_idex  = (st || fl) ? 9'd0 : expect_dec(op);
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        opcode = 6'h00; stall = 1'b0; flush = 1'b0; rst = 1'b1;
        @(negedge clk);
        // R9: reset with active-looking inputs
        tag = "R9";
        step(6'h23, 1'b0, 1'b0, 1'b1);
        step(6'h00, 1'b0, 1'b0, 1'b1);
        step(6'h04, 1'b0, 1'b0, 1'b1);

        // R1, R6: single register-register op followed by idle codes
        tag = "R1";
        step(6'h00, 1'b0, 1'b0, 1'b0);
        tag = "R6";
        step(6'h3F, 1'b0, 1'b0, 1'b0);
        step(6'h3F, 1'b0, 1'b0, 1'b0);
        step(6'h3F, 1'b0, 1'b0, 1'b0);
        // R2
        tag = "R2";
        step(6'h23, 1'b0, 1'b0, 1'b0);
        // R3
        tag = "R3";
        step(6'h2B, 1'b0, 1'b0, 1'b0);
        // R4
        tag = "R4";
        step(6'h04, 1'b0, 1'b0, 1'b0);
        // R5: unknown codes
        tag = "R5";
        step(6'h01, 1'b0, 1'b0, 1'b0);
        step(6'h22, 1'b0, 1'b0, 1'b0);
        step(6'h2A, 1'b0, 1'b0, 1'b0);
        step(6'h05, 1'b0, 1'b0, 1'b0);

        // R7: load then dependent op stalled, older load keeps moving
        tag = "R7";
        step(6'h23, 1'b0, 1'b0, 1'b0);
        step(6'h00, 1'b1, 1'b0, 1'b0);
        step(6'h00, 1'b0, 1'b0, 1'b0);
        step(6'h00, 1'b1, 1'b0, 1'b0);
        step(6'h2B, 1'b1, 1'b0, 1'b0);
        step(6'h2B, 1'b0, 1'b0, 1'b0);

        // R8: flush alone and together with stall
        tag = "R8";
        step(6'h04, 1'b0, 1'b0, 1'b0);
        step(6'h23, 1'b0, 1'b1, 1'b0);
        step(6'h00, 1'b0, 1'b0, 1'b0);
        step(6'h23, 1'b1, 1'b1, 1'b0);
        step(6'h2B, 1'b0, 1'b1, 1'b0);
        step(6'h3F, 1'b0, 1'b0, 1'b0);

        // R9: reset in the middle of a full pipeline
        tag = "R9";
        step(6'h23, 1'b0, 1'b0, 1'b0);
        step(6'h00, 1'b0, 1'b0, 1'b0);
        step(6'h23, 1'b0, 1'b0, 1'b1);
        step(6'h00, 1'b1, 1'b1, 1'b1);
        step(6'h00, 1'b0, 1'b0, 1'b0);

        // R10 and mixed traffic: pseudo-random opcodes and requests
        tag = "R10";
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            logic [5:0] op;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (lfsr[2:0])
                3'd0, 3'd1: op = 6'h00;
                3'd2:       op = 6'h23;
                3'd3:       op = 6'h2B;
                3'd4:       op = 6'h04;
                default:    op = {lfsr[7:3], lfsr[0]};
            endcase
            step(op, (lfsr[7:5] == 3'd0), (lfsr[6:4] == 3'd7), (i % 97 == 50));
            checks++;
            if (!((mem_ctl == 3'b000) || (mem_ctl == 3'b001) ||
                  (mem_ctl == 3'b010) || (mem_ctl == 3'b100))) begin
                fails++;
                $display("FAIL R10 mem_ctl actual=%b expected=one-hot-or-zero", mem_ctl);
            end
            checks++;
            if (wb_ctl == 2'b01) begin
                fails++;
                $display("FAIL R10 wb_ctl actual=%b expected=not 01", wb_ctl);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule